// File: doc/BRIEF.md
# Two-Wire Master Transaction Sequencer

This block runs one master transaction on an I2C/SMBus-style two-wire bus on behalf of software. Software drives it through a small byte-wide register port. A write to the control register requests a start or a stop. A write to the data register is taken as the target address when the sequencer is idle, or as a payload byte while it is sending. A read of the data register returns the last received byte and, while receiving, asks the bus for the next one. The status bits report master mode, direction, data-register readiness, a missing acknowledge, a lost start and a stall after the address phase.

On the bus side the block does not generate clocks or bit timing. It talks to a byte-level bus agent with single-cycle request pulses: address plus direction, send byte, receive byte, and end of transfer. Each request waits for one done pulse, which carries the acknowledge and the received byte. A stop is not always carried out when it is requested. During a receive it is held until software has read the last byte. After a missing acknowledge it is held until software clears the NACK flag.

Register offsets are: 0 data, 1 status, 2 bus status, 3 control1, 4 control2, 5 status3. The status register bits are SDAST at 6, BER at 5, NEGACK at 4, STASTR at 3, MODE at 1 and XMIT at 0. Bits 7 and 2 of the status register read as zero.

Top module: `tw_seq`

## Requirements
- R1: After reset, every register reads 0 and no bus request is raised.
- R2: Writing 1 to control1 bit 0 starts a transaction. The start succeeds when `bus_busy_i` is low, or when the sequencer is not idle (a repeated start). On success MODE, XMIT, SDAST and BUSY (bus status bit 0) are set. On failure MODE and BUSY are cleared and BER is set. In both cases BB (bus status bit 1) is set and the sequencer returns to idle.
- R3: A data write while MODE is set and the sequencer is idle raises a one-cycle address request. The target is write-data bits 7:1 and the direction is bit 0 (1 = read). SDAST reads 0 while the request is outstanding. No further request is raised until the done pulse arrives.
- R4: If an address or a payload byte is not acknowledged, SDAST is cleared, NEGACK is set and the sequencer enters the NACK state. After an address NACK, XMIT is the inverse of the direction bit.
- R5: An acknowledged write address enters sending with XMIT=1 and SDAST=1. Each later data write raises a send request carrying the byte. An acknowledged send sets SDAST again.
- R6: An acknowledged read address clears NEGACK and XMIT and enters receiving. If control1 bit 7 (stall) is set, STASTR and SDAST are set and no receive request is raised. Otherwise a receive request is raised at once. The returned byte lands in the data register and SDAST is set.
- R7: While receiving, a data read returns the held byte and raises a receive request. Writing 1 to status bit 3 while receiving clears STASTR and also raises a receive request.
- R8: A stop request (control1 bit 1) while receiving is deferred. The next data read returns the held byte and raises an end request.
- R9: A stop request in the NACK state is deferred until software writes 1 to status bit 4. In any other state with MODE set the end request is raised at once. With MODE clear the stop request has no effect.
- R10: When the end request is done, the sequencer returns to idle, so the next data write is an address. Status3 bit 7 (end-of-busy) is set and is cleared by writing 1 to it.
- R11: BER (status bit 5), STASTR (status bit 3) and BB (bus status bit 1) are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R12: Control1 bits 0 (start), 1 (stop) and 4 (ack) are never stored and read as 0. The other control1 bits read back as written.
- R13: Writing control2 with bit 0 (enable) at 0 clears end-of-busy and flushes the data register to 0.
- R14: A data write is ignored in the following cases: MODE is clear, the sequencer is neither idle nor sending, or a bus request is outstanding. The ignored write raises no bus request, and `err_o` is high for the one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_i | input | 1 | Register write strobe |
| sw_rd_i | input | 1 | Register read strobe |
| sw_addr_i | input | ADDR_W | Register offset |
| sw_wdata_i | input | 8 | Write data |
| sw_rdata_o | output | 8 | Read data, valid in the same cycle as the read strobe |
| err_o | output | 1 | One-cycle pulse after an ignored data write |
| bus_busy_i | input | 1 | Another master holds the bus |
| bus_start_o | output | 1 | Address-phase request pulse |
| bus_tgt_o | output | 7 | Target address of the request |
| bus_read_o | output | 1 | Direction of the request, 1 = read |
| bus_send_o | output | 1 | Send-byte request pulse |
| bus_wbyte_o | output | 8 | Byte to send |
| bus_recv_o | output | 1 | Receive-byte request pulse |
| bus_end_o | output | 1 | End-of-transfer request pulse |
| bus_done_i | input | 1 | Completion pulse for the outstanding request |
| bus_ack_i | input | 1 | Acknowledge returned with the done pulse |
| bus_rbyte_i | input | 8 | Byte returned with a receive done pulse |

## Verification
The assertions assume that the bus agent gives exactly one done pulse per request and never gives one while nothing is outstanding. They also assume that software accesses at most one register per cycle and never sets start and stop in the same control1 write. The bench responder answers each request after a fixed delay and only once. The bench issues one register access at a time and gives each transaction time to settle before the next step. It checks separately that no request is raised while another is still open.

// File: rtl/tw_seq_pkg.sv
package tw_seq_pkg;

  localparam int DATA_W = 8;

  // register offsets
  localparam int REG_DATA  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_BUS   = 2;
  localparam int REG_CTL1  = 3;
  localparam int REG_CTL2  = 4;
  localparam int REG_STAT3 = 5;

  // control1 bits that a write never stores: start(0), stop(1), ack(4)
  localparam logic [DATA_W-1:0] CTL1_VOLATILE = 8'h13;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SEND, SQ_RECV, SQ_NACK, SQ_STOP_RX, SQ_STOP_NACK
  } seq_state_e;

  typedef enum logic [2:0] {
    WT_NONE, WT_ADDR, WT_SEND, WT_RECV, WT_END
  } wait_e;

  typedef struct packed {
    logic mode;
    logic xmit;
    logic sdast;
    logic negack;
    logic ber;
    logic stastr;
    logic bb;
    logic busy;
    logic eob;
  } flags_t;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic stat_wr;
    logic bus_wr;
    logic ctl1_wr;
    logic ctl2_wr;
    logic stat3_wr;
  } sel_t;

  function automatic logic [DATA_W-1:0] pack_status(flags_t f);
    return {1'b0, f.sdast, f.ber, f.negack, f.stastr, 1'b0, f.mode, f.xmit};
  endfunction

  function automatic logic [DATA_W-1:0] pack_bus(flags_t f);
    return {6'b0, f.bb, f.busy};
  endfunction

  function automatic logic [DATA_W-1:0] ctl1_store(logic [DATA_W-1:0] v);
    return v & ~CTL1_VOLATILE;
  endfunction

endpackage

// File: rtl/tw_seq_decode.sv
module tw_seq_decode
  import tw_seq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o
);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(REG_DATA);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_BUS   = ADDR_W'(REG_BUS);
  localparam logic [ADDR_W-1:0] A_CTL1  = ADDR_W'(REG_CTL1);
  localparam logic [ADDR_W-1:0] A_CTL2  = ADDR_W'(REG_CTL2);
  localparam logic [ADDR_W-1:0] A_STAT3 = ADDR_W'(REG_STAT3);

  always_comb begin
    sel_o.data_wr  = wr_i && (addr_i == A_DATA);
    sel_o.data_rd  = rd_i && !wr_i && (addr_i == A_DATA);
    sel_o.stat_wr  = wr_i && (addr_i == A_STAT);
    sel_o.bus_wr   = wr_i && (addr_i == A_BUS);
    sel_o.ctl1_wr  = wr_i && (addr_i == A_CTL1);
    sel_o.ctl2_wr  = wr_i && (addr_i == A_CTL2);
    sel_o.stat3_wr = wr_i && (addr_i == A_STAT3);
  end
endmodule

// File: rtl/tw_seq_engine.sv
module tw_seq_engine
  import tw_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sel_t              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bus_busy_i,
  input  logic              bus_done_i,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rbyte_i,
  output logic              bus_start_o,
  output logic [DATA_W-2:0] bus_tgt_o,
  output logic              bus_read_o,
  output logic              bus_send_o,
  output logic [DATA_W-1:0] bus_wbyte_o,
  output logic              bus_recv_o,
  output logic              bus_end_o,
  output logic              err_o,
  output flags_t            flags_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] ctl1_o,
  output logic [DATA_W-1:0] ctl2_o
);
  flags_t            flg, n;
  seq_state_e        st, n_st;
  wait_e             wt, n_wt;
  logic [DATA_W-1:0] data_q, n_data, ctl1_q, n_ctl1, ctl2_q, n_ctl2, wb_q, n_wb;
  logic [DATA_W-2:0] tgt_q, n_tgt;
  logic              dir_q, n_dir;
  logic              r_addr, r_send, r_recv, r_end, n_err, do_stop, avail;

  // named events for the assertions
  logic ev_start, ev_stop, ev_done;
  assign ev_start = sel_i.ctl1_wr && wdata_i[0];
  assign ev_stop  = sel_i.ctl1_wr && wdata_i[1] && !wdata_i[0];
  assign ev_done  = bus_done_i && (wt != WT_NONE);

  always_comb begin
    n = flg; n_st = st; n_wt = wt; n_data = data_q;
    n_ctl1 = ctl1_q; n_ctl2 = ctl2_q; n_tgt = tgt_q; n_dir = dir_q; n_wb = wb_q;
    r_addr = 1'b0; r_send = 1'b0; r_recv = 1'b0; r_end = 1'b0;
    n_err = 1'b0; do_stop = 1'b0; avail = 1'b0;

    // write-one-to-clear flags and plain control stores
    if (sel_i.stat_wr) begin
      if (wdata_i[5]) n.ber    = 1'b0;
      if (wdata_i[4]) n.negack = 1'b0;
      if (wdata_i[3]) n.stastr = 1'b0;
    end
    if (sel_i.bus_wr && wdata_i[1])   n.bb  = 1'b0;
    if (sel_i.stat3_wr && wdata_i[7]) n.eob = 1'b0;
    if (sel_i.ctl1_wr) n_ctl1 = ctl1_store(wdata_i);
    if (sel_i.ctl2_wr) begin
      n_ctl2 = wdata_i;
      if (!wdata_i[0]) begin
        n.eob  = 1'b0;
        n_data = '0;
      end
    end

    if (wt != WT_NONE) begin
      if (sel_i.data_wr) n_err = 1'b1;
      if (bus_done_i) begin
        n_wt = WT_NONE;
        case (wt)
          WT_ADDR: begin
            if (!bus_ack_i) begin
              n.xmit = !dir_q; n.sdast = 1'b0; n.negack = 1'b1; n_st = SQ_NACK;
            end else begin
              n.negack = 1'b0;
              if (dir_q) begin
                n_st = SQ_RECV; n.xmit = 1'b0;
                if (ctl1_q[7]) begin
                  n.stastr = 1'b1; n.sdast = 1'b1;
                end else begin
                  n.sdast = 1'b0; r_recv = 1'b1; n_wt = WT_RECV;
                end
              end else begin
                n_st = SQ_SEND; n.xmit = 1'b1; n.sdast = 1'b1;
              end
            end
          end
          WT_SEND: begin
            if (!bus_ack_i) begin
              n.sdast = 1'b0; n.negack = 1'b1; n_st = SQ_NACK;
            end else begin
              n.sdast = 1'b1;
            end
          end
          WT_RECV: begin
            n_data = bus_rbyte_i; n.sdast = 1'b1;
          end
          WT_END: begin
            n_st = SQ_IDLE; n.eob = 1'b1;
          end
          default: ;
        endcase
      end
    end else begin
      if (ev_start) begin
        avail = !bus_busy_i || (st != SQ_IDLE);
        if (avail) begin
          n.mode = 1'b1; n.xmit = 1'b1; n.sdast = 1'b1; n.busy = 1'b1;
        end else begin
          n.mode = 1'b0; n.busy = 1'b0; n.ber = 1'b1;
        end
        n.bb = 1'b1;
        n_st = SQ_IDLE;
      end else if (ev_stop && flg.mode) begin
        case (st)
          SQ_RECV, SQ_STOP_RX: n_st = SQ_STOP_RX;
          SQ_NACK:             n_st = SQ_STOP_NACK;
          default:             do_stop = 1'b1;
        endcase
      end

      if (sel_i.data_wr) begin
        if (flg.mode && st == SQ_IDLE) begin
          n_tgt = wdata_i[DATA_W-1:1]; n_dir = wdata_i[0];
          r_addr = 1'b1; n_wt = WT_ADDR; n.sdast = 1'b0;
        end else if (flg.mode && st == SQ_SEND) begin
          n_wb = wdata_i; r_send = 1'b1; n_wt = WT_SEND; n.sdast = 1'b0;
        end else begin
          n_err = 1'b1;
        end
      end

      if (sel_i.data_rd) begin
        if (st == SQ_STOP_RX) begin
          do_stop = 1'b1;
        end else if (st == SQ_RECV) begin
          r_recv = 1'b1; n_wt = WT_RECV; n.sdast = 1'b0;
        end
      end

      if (sel_i.stat_wr && wdata_i[4] && st == SQ_STOP_NACK) do_stop = 1'b1;
      if (sel_i.stat_wr && wdata_i[3] && st == SQ_RECV) begin
        r_recv = 1'b1; n_wt = WT_RECV; n.sdast = 1'b0;
      end
    end

    if (do_stop) begin
      r_end = 1'b1; n_wt = WT_END;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg <= '0; st <= SQ_IDLE; wt <= WT_NONE; data_q <= '0;
      ctl1_q <= '0; ctl2_q <= '0; tgt_q <= '0; dir_q <= 1'b0; wb_q <= '0;
      bus_start_o <= 1'b0; bus_send_o <= 1'b0; bus_recv_o <= 1'b0;
      bus_end_o <= 1'b0; err_o <= 1'b0;
    end else begin
      flg <= n; st <= n_st; wt <= n_wt; data_q <= n_data;
      ctl1_q <= n_ctl1; ctl2_q <= n_ctl2; tgt_q <= n_tgt; dir_q <= n_dir; wb_q <= n_wb;
      bus_start_o <= r_addr; bus_send_o <= r_send; bus_recv_o <= r_recv;
      bus_end_o <= r_end; err_o <= n_err;
    end
  end

  assign bus_tgt_o   = tgt_q;
  assign bus_read_o  = dir_q;
  assign bus_wbyte_o = wb_q;
  assign flags_o     = flg;
  assign data_o      = data_q;
  assign ctl1_o      = ctl1_q;
  assign ctl2_o      = ctl2_q;

  AST_NO_REQ_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wt != WT_NONE && !bus_done_i) |=> !(bus_start_o || bus_send_o || bus_recv_o || bus_end_o)); // R3
  AST_START_FAIL_BER: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && wt == WT_NONE && st == SQ_IDLE && bus_busy_i) |=> (flg.ber && !flg.mode && flg.bb)); // R2
  AST_SEND_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && wt == WT_SEND && !bus_ack_i) |=> (st == SQ_NACK && flg.negack && !flg.sdast)); // R4
  AST_STOP_DEFER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && wt == WT_NONE && flg.mode && st == SQ_RECV) |=> (!bus_end_o && st == SQ_STOP_RX)); // R8
  AST_END_SETS_EOB: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && wt == WT_END) |=> (flg.eob && st == SQ_IDLE)); // R10
  AST_BAD_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i.data_wr && wt == WT_NONE && !(flg.mode && (st == SQ_IDLE || st == SQ_SEND)))
      |=> (err_o && !bus_start_o && !bus_send_o)); // R14
endmodule

// File: rtl/tw_seq_rdmux.sv
module tw_seq_rdmux
  import tw_seq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  flags_t            flags_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ctl1_i,
  input  logic [DATA_W-1:0] ctl2_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    case (int'(addr_i))
      REG_DATA:  rdata_o = data_i;
      REG_STAT:  rdata_o = pack_status(flags_i);
      REG_BUS:   rdata_o = pack_bus(flags_i);
      REG_CTL1:  rdata_o = ctl1_i;
      REG_CTL2:  rdata_o = ctl2_i;
      REG_STAT3: rdata_o = {flags_i.eob, {(DATA_W-1){1'b0}}};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_seq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_i,
  input  logic              sw_rd_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic [7:0]        sw_wdata_i,
  output logic [7:0]        sw_rdata_o,
  output logic              err_o,
  input  logic              bus_busy_i,
  output logic              bus_start_o,
  output logic [6:0]        bus_tgt_o,
  output logic              bus_read_o,
  output logic              bus_send_o,
  output logic [7:0]        bus_wbyte_o,
  output logic              bus_recv_o,
  output logic              bus_end_o,
  input  logic              bus_done_i,
  input  logic              bus_ack_i,
  input  logic [7:0]        bus_rbyte_i
);
  sel_t              sel;
  flags_t            flags;
  logic [DATA_W-1:0] data_q, ctl1_q, ctl2_q;

  tw_seq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_i(sw_wr_i), .rd_i(sw_rd_i), .addr_i(sw_addr_i), .sel_o(sel)
  );

  tw_seq_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .wdata_i(sw_wdata_i),
    .bus_busy_i(bus_busy_i), .bus_done_i(bus_done_i), .bus_ack_i(bus_ack_i),
    .bus_rbyte_i(bus_rbyte_i), .bus_start_o(bus_start_o), .bus_tgt_o(bus_tgt_o),
    .bus_read_o(bus_read_o), .bus_send_o(bus_send_o), .bus_wbyte_o(bus_wbyte_o),
    .bus_recv_o(bus_recv_o), .bus_end_o(bus_end_o), .err_o(err_o),
    .flags_o(flags), .data_o(data_q), .ctl1_o(ctl1_q), .ctl2_o(ctl2_q)
  );

  tw_seq_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr_i(sw_addr_i), .flags_i(flags), .data_i(data_q),
    .ctl1_i(ctl1_q), .ctl2_i(ctl2_q), .rdata_o(sw_rdata_o)
  );
endmodule

// File: tb/tw_seq_bench.sv
module tw_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_wr = 1'b0, sw_rd = 1'b0;
  logic [2:0] sw_addr = '0;
  logic [7:0] sw_wdata = '0, sw_rdata;
  logic err, bus_busy = 1'b0;
  logic b_start, b_read, b_send, b_recv, b_end;
  logic [6:0] b_tgt;
  logic [7:0] b_wbyte;
  logic b_done = 1'b0, b_ack = 1'b0;
  logic [7:0] b_rbyte = '0;

  always #5 clk = ~clk;

  tw_seq u_tw_seq (
    .clk(clk), .rst_n(rst_n), .sw_wr_i(sw_wr), .sw_rd_i(sw_rd), .sw_addr_i(sw_addr),
    .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata), .err_o(err), .bus_busy_i(bus_busy),
    .bus_start_o(b_start), .bus_tgt_o(b_tgt), .bus_read_o(b_read), .bus_send_o(b_send),
    .bus_wbyte_o(b_wbyte), .bus_recv_o(b_recv), .bus_end_o(b_end), .bus_done_i(b_done),
    .bus_ack_i(b_ack), .bus_rbyte_i(b_rbyte)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  // bus agent reference model
  bit resp_ack = 1;
  int rxq[$];
  int n_addr = 0, n_send = 0, n_recv = 0, n_end = 0, cnt = 0;
  bit outst = 0, is_recv = 0;
  logic [6:0] seen_tgt = '0;
  logic seen_rd = 1'b0;
  logic [7:0] seen_wb = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // agent: answers each request after a fixed delay, checked every clock
  always @(negedge clk) begin
    if (b_done) begin b_done = 1'b0; outst = 0; end
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        b_done = 1'b1; b_ack = resp_ack;
        if (is_recv && rxq.size() > 0) b_rbyte = 8'(rxq.pop_front());
      end
    end
    if (rst_n && (b_start || b_send || b_recv || b_end)) begin
      chk("R3 one request at a time", {31'd0, outst}, 32'd0);
      chk("R3 single request pulse", 32'(b_start + b_send + b_recv + b_end), 32'd1);
      outst = 1; cnt = 2; is_recv = b_recv;
      if (b_start) begin n_addr++; seen_tgt = b_tgt; seen_rd = b_read; end
      if (b_send) begin n_send++; seen_wb = b_wbyte; end
      if (b_recv) n_recv++;
      if (b_end) n_end++;
    end
  end

  task automatic wr(input int a, input int d);
    sw_addr = 3'(a); sw_wdata = 8'(d); sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    sw_addr = 3'(a); sw_rd = 1'b1;
    #1 v = sw_rdata;
    @(negedge clk);
    sw_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input int a, input int e);
    logic [7:0] v;
    rd(a, v);
    chk(req, {24'd0, v}, 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ea, er, ee;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) expect_reg("R1 reset value", a, 0);
    chk("R1 no request", 32'(n_addr + n_send + n_recv + n_end), 32'd0);

    // R9 stop with MODE clear; R14 data write with MODE clear
    wr(3, 8'h02); settle();
    chk("R9 stop without MODE", 32'(n_end), 32'd0);
    wr(0, 8'hA4);
    chk("R14 err pulse", {31'd0, err}, 32'd1);
    settle();
    chk("R14 no address request", 32'(n_addr), 32'd0);

    // R2 failed start
    bus_busy = 1'b1;
    wr(3, 8'h01); settle();
    expect_reg("R2 failed start status", 1, 8'h20);
    expect_reg("R2 failed start bus", 2, 8'h02);
    wr(1, 8'h00); expect_reg("R11 write 0 keeps BER", 1, 8'h20);
    wr(1, 8'h20); expect_reg("R11 BER clear", 1, 8'h00);
    wr(2, 8'h02); expect_reg("R11 BB clear", 2, 8'h00);

    // R2 successful start
    bus_busy = 1'b0;
    wr(3, 8'h01); settle();
    expect_reg("R2 start status", 1, 8'h43);
    expect_reg("R2 start bus", 2, 8'h03);

    // R12 control1 storage
    wr(3, 8'hF8); expect_reg("R12 ctl1 readback", 3, 8'hE8);
    wr(3, 8'h00);

    // R3/R5 write address
    resp_ack = 1;
    wr(0, 8'hA4);
    expect_reg("R3 SDAST low while outstanding", 1, 8'h03);
    settle();
    chk("R3 address request", 32'(n_addr), 32'd1);
    chk("R3 target", {25'd0, seen_tgt}, 32'h52);
    chk("R3 direction", {31'd0, seen_rd}, 32'd0);
    expect_reg("R5 sending status", 1, 8'h43);

    // R5 payload acked
    wr(0, 8'h5A); settle();
    chk("R5 send byte", {24'd0, seen_wb}, 32'h5A);
    expect_reg("R5 send acked", 1, 8'h43);

    // R4 payload NACK
    resp_ack = 0;
    wr(0, 8'h33); settle();
    expect_reg("R4 payload nack status", 1, 8'h13);
    wr(0, 8'h44);
    chk("R14 err in NACK", {31'd0, err}, 32'd1);

    // R9 deferred stop on NACK, R10 completion
    ee = n_end;
    wr(3, 8'h02); settle();
    chk("R9 stop deferred in NACK", 32'(n_end), 32'(ee));
    wr(1, 8'h10); settle();
    chk("R9 NEGACK clear ends", 32'(n_end), 32'(ee + 1));
    expect_reg("R10 eob set", 5, 8'h80);
    expect_reg("R9 status after stop", 1, 8'h03);
    wr(5, 8'h80); expect_reg("R10 eob clear", 5, 8'h00);

    // R4 address NACK on read, R10 idle accepts address
    ea = n_addr;
    wr(0, 8'h91); settle();
    chk("R10 idle takes address", 32'(n_addr), 32'(ea + 1));
    expect_reg("R4 address nack read", 1, 8'h12);
    wr(3, 8'h02); wr(1, 8'h10); settle();
    wr(5, 8'h80);

    // R2 repeated start while bus busy
    resp_ack = 1;
    wr(3, 8'h01); settle();
    wr(0, 8'hA4); settle();
    bus_busy = 1'b1;
    wr(3, 8'h01); settle();
    expect_reg("R2 repeated start status", 1, 8'h43);
    expect_reg("R2 repeated start bus", 2, 8'h03);
    bus_busy = 1'b0;

    // R9 immediate stop
    ee = n_end;
    wr(3, 8'h02); settle();
    chk("R9 immediate stop", 32'(n_end), 32'(ee + 1));
    wr(5, 8'h80);

    // R6/R7/R8 receive without stall
    rxq.push_back(8'h11); rxq.push_back(8'h22); rxq.push_back(8'h33);
    er = n_recv;
    wr(3, 8'h01); settle();
    wr(0, 8'hA5); settle();
    chk("R6 immediate receive", 32'(n_recv), 32'(er + 1));
    expect_reg("R6 receive status", 1, 8'h42);
    expect_reg("R7 first byte", 0, 8'h11);
    settle();
    chk("R7 read fetches", 32'(n_recv), 32'(er + 2));
    ee = n_end;
    wr(3, 8'h02); settle();
    chk("R8 stop deferred in receive", 32'(n_end), 32'(ee));
    expect_reg("R8 last byte", 0, 8'h22);
    settle();
    chk("R8 read ends", 32'(n_end), 32'(ee + 1));
    chk("R8 no fetch on last read", 32'(n_recv), 32'(er + 2));
    expect_reg("R10 eob after receive", 5, 8'h80);

    // R6/R7 stall after address
    wr(3, 8'h81); settle();
    er = n_recv;
    wr(0, 8'hA5); settle();
    chk("R6 stall no receive", 32'(n_recv), 32'(er));
    expect_reg("R6 stall status", 1, 8'h4A);
    wr(1, 8'h08); settle();
    chk("R7 STASTR fetches", 32'(n_recv), 32'(er + 1));
    expect_reg("R7 STASTR cleared", 1, 8'h42);
    wr(3, 8'h02); expect_reg("R7 stalled byte", 0, 8'h33);
    settle();

    // R13 disable flushes
    wr(4, 8'h01);
    expect_reg("R13 eob before", 5, 8'h80);
    wr(4, 8'h00);
    expect_reg("R13 eob cleared", 5, 8'h00);
    expect_reg("R13 data flushed", 0, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule